// File: doc/BRIEF.md
# Stacked-Carrier PWM Modulator for a 21-Step Inverter

This block turns a signed reference sample into gate commands for a single-phase inverter that can produce 21 output steps, from -10 to +10 units. The reference is first scaled by a modulation index. It is then compared against twenty triangular carriers that are generated inside the block. Each carrier sits in its own amplitude band, ten above zero and ten below. The signed count of carriers that the reference crosses is the output step.

The step is registered and decoded into twelve gate lines:

- Four legs carry source weights of 1, 2, 3 and 4 units. Each leg has an "insert" switch and a "bypass" switch.
- A two-pair polarity bridge selects the sign of the output.

A mode input chooses how the carriers are phased against each other:

- all carriers in phase;
- the negative bands inverted;
- every band opposite to its neighbours.

The carrier advances one count per tick. A tick comes every `TICK_DIV` clocks. The triangle runs from 0 up to `CAR_MAX` and back down to 0, so one carrier period is `2*CAR_MAX` ticks. The upstream source supplies one reference sample per tick.

Top module: `lvl_pwm_mod`

## Requirements
- R1: After reset the shared triangle starts at 0 and rises. On each tick it moves one count, turning at `CAR_MAX` and at 0, so one carrier period is `2*CAR_MAX` ticks.
- R2: Carrier band b (0..9) above zero spans b·CAR_MAX to (b+1)·CAR_MAX. Band b below zero spans -(b+1)·CAR_MAX to -b·CAR_MAX. The step equals the number of upper-band carriers strictly below the scaled reference, minus the number of lower-band carriers strictly above it.
- R3: With `modeSel` = 0 every band uses the rising form of the triangle, base + tri. The value 3 behaves the same as 0.
- R4: With `modeSel` = 1 the upper bands use base + tri and every lower band uses the inverted form, base + CAR_MAX − tri.
- R5: With `modeSel` = 2 the upper bands with odd index and the lower bands with even index are inverted, so that every band is opposite to its neighbour.
- R6: The scaled reference is (refIn · modIdx) shifted right arithmetically by 7 bits. `modIdx` is unsigned, and 128 means unity gain.
- R7: `levelOut` never leaves -10..+10. An overdriven reference saturates at ±10.
- R8: Leg k uses gate bit 2k to insert its source and gate bit 2k+1 to bypass it. The leg weights are 1, 2, 3 and 4 for k = 0..3. The inserted weights always add up to |level|, with these selections:

  | \|level\| | Legs inserted |
  |---|---|
  | 10 | all four |
  | 9 | 2+3+4 |
  | 8 | 1+3+4 |
  | 7 | 3+4 |
  | 6 | 1+2+3 |
  | 5 | 1+4 |
  | 4 | 4 |
  | 3 | 1+2 |
  | 2 | 2 |
  | 1 | 1 |
  | 0 | none |

- R9: The insert and bypass switches of one leg are never on together.
- R10: Gate bits 8 and 9 are both on for a level of zero or above. Gate bits 10 and 11 are both on for a negative level. The two bridge pairs are never on together.
- R11: `levelOut` and `gateOut` are registered. The value after a tick edge reflects the triangle value and inputs from before that edge. After the first update following reset, the gates change only when the level changes.
- R12: A synchronous reset gives level 0 with all four bypass switches on and the whole polarity bridge off (`gateOut` = 0x0AA).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | REF_W | Signed reference sample |
| modIdx | input | 8 | Unsigned modulation index, 128 = unity |
| modeSel | input | 2 | Carrier phase arrangement: 0 all in phase, 1 lower bands inverted, 2 alternating, 3 same as 0 |
| levelOut | output | 5 | Signed output step, -10..+10 |
| gateOut | output | 12 | Gate lines: legs at bits 0..7 (insert even, bypass odd), bridge at bits 8..11 |

## Verification
The bench runs with one tick per clock. A fresh reference, index and mode are applied every cycle. Each result is due on the first rising edge after those inputs are applied, and it is computed from the triangle value held one edge earlier. The bench keeps its own count of edges since reset. From that count it derives the triangle value the design saw, and it checks outputs on the falling edge that follows the capturing edge. References are swept over more than the full carrier span in all modes and at several index values. Every sample is checked against the stacked-band arithmetic, the weighted leg sum, the leg exclusivity and the bridge polarity.

// File: rtl/lvl_pwm_pkg.sv
package lvl_pwm_pkg;

  localparam int HALF_LVL = 10;
  localparam int LVL_W    = $clog2(HALF_LVL + 1) + 1;
  localparam int NUM_LEGS = 4;
  localparam int GATE_W   = 2 * NUM_LEGS + 4;
  localparam int MI_W     = 8;
  localparam int MI_FRAC  = 7;

  typedef enum logic [1:0] {
    CAR_PD    = 2'd0,
    CAR_POD   = 2'd1,
    CAR_APOD  = 2'd2,
    CAR_SPARE = 2'd3
  } carMode_e;

  typedef struct packed {
    logic tick;
  } ctrlStrobe_t;

  // magnitude -> inserted legs, bit k = leg of weight k+1
  function automatic logic [NUM_LEGS-1:0] legSelect(input logic [3:0] mag);
    case (mag)
      4'd10:   legSelect = 4'b1111;
      4'd9:    legSelect = 4'b1110;
      4'd8:    legSelect = 4'b1101;
      4'd7:    legSelect = 4'b1100;
      4'd6:    legSelect = 4'b0111;
      4'd5:    legSelect = 4'b1001;
      4'd4:    legSelect = 4'b1000;
      4'd3:    legSelect = 4'b0011;
      4'd2:    legSelect = 4'b0010;
      4'd1:    legSelect = 4'b0001;
      default: legSelect = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/lvl_pwm_ctrl.sv
module lvl_pwm_ctrl
  import lvl_pwm_pkg::*;
#(
  parameter int CAR_MAX  = 100,
  parameter int TICK_DIV = 1,
  parameter int TRI_W    = $clog2(CAR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output ctrlStrobe_t       strobe,
  output logic [TRI_W-1:0]  triVal
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             upQ;
  logic [TRI_W-1:0] triQ;

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  // R1: triangle 0 -> CAR_MAX -> 0, one count per tick
  always_ff @(posedge clk) begin
    if (rst) begin
      triQ <= '0;
      upQ  <= 1'b1;
    end else if (tick) begin
      if (upQ) begin
        triQ <= triQ + 1'b1;
        if (triQ == TRI_W'(CAR_MAX - 1)) upQ <= 1'b0;
      end else begin
        triQ <= triQ - 1'b1;
        if (triQ == TRI_W'(1)) upQ <= 1'b1;
      end
    end
  end

  assign strobe.tick = tick;
  assign triVal      = triQ;

endmodule

// File: rtl/lvl_pwm_datapath.sv
module lvl_pwm_datapath
  import lvl_pwm_pkg::*;
#(
  parameter int REF_W   = 16,
  parameter int CAR_MAX = 100,
  parameter int TRI_W   = $clog2(CAR_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStrobe_t             strobe,
  input  logic [TRI_W-1:0]        triVal,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [MI_W-1:0]         modIdx,
  input  logic [1:0]              modeSel,
  output logic signed [LVL_W-1:0] levelOut,
  output logic [GATE_W-1:0]       gateOut
);

  localparam int CW = REF_W + MI_W + 1;
  localparam logic [GATE_W-1:0] GATE_RST = {4'b0000, {NUM_LEGS{2'b10}}};

  logic signed [CW-1:0] product, scaledRef;
  logic signed [CW-1:0] triUp, triDn;
  carMode_e             mode;
  logic [HALF_LVL-1:0]  posHit, negHit;

  // R6: modulation index in Q1.7
  assign product   = $signed(refIn) * $signed({1'b0, modIdx});
  assign scaledRef = product >>> MI_FRAC;
  assign mode      = carMode_e'(modeSel);
  assign triUp     = CW'(triVal);
  assign triDn     = CW'(CAR_MAX) - CW'(triVal);

  // R2..R5: stacked bands with per-mode inversion
  for (genvar b = 0; b < HALF_LVL; b++) begin : g_band
    logic posInv, negInv;
    logic signed [CW-1:0] posCar, negCar;
    assign posInv = (mode == CAR_APOD) && ((b % 2) == 1);
    assign negInv = (mode == CAR_POD) || ((mode == CAR_APOD) && ((b % 2) == 0));
    assign posCar = CW'(b * CAR_MAX) + (posInv ? triDn : triUp);
    assign negCar = CW'(-(b + 1) * CAR_MAX) + (negInv ? triDn : triUp);
    assign posHit[b] = scaledRef > posCar;
    assign negHit[b] = negCar > scaledRef;
  end

  int                     lvlRaw;
  logic signed [LVL_W-1:0] lvlNext;
  logic [3:0]             magNext;
  logic [NUM_LEGS-1:0]    legs;
  logic [GATE_W-1:0]      gateNext;

  always_comb begin
    lvlRaw = int'($countones(posHit)) - int'($countones(negHit));
    if (lvlRaw > HALF_LVL)       lvlNext = LVL_W'(HALF_LVL);
    else if (lvlRaw < -HALF_LVL) lvlNext = LVL_W'(-HALF_LVL);
    else                         lvlNext = LVL_W'(lvlRaw);
    magNext = (lvlNext < 0) ? 4'(-lvlNext) : 4'(lvlNext);
  end

  assign legs = legSelect(magNext);

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    assign gateNext[2*k]   = legs[k];
    assign gateNext[2*k+1] = ~legs[k];
  end
  assign gateNext[GATE_W-1:2*NUM_LEGS] = (lvlNext < 0) ? 4'b1100 : 4'b0011;

  logic armed;

  // R11/R12: registered, update only on a level change
  always_ff @(posedge clk) begin
    if (rst) begin
      levelOut <= '0;
      gateOut  <= GATE_RST;
      armed    <= 1'b0;
    end else if (strobe.tick && (!armed || (lvlNext != levelOut))) begin
      levelOut <= lvlNext;
      gateOut  <= gateNext;
      armed    <= 1'b1;
    end
  end

endmodule

// File: rtl/lvl_pwm_mod.sv
module lvl_pwm_mod
  import lvl_pwm_pkg::*;
#(
  parameter int REF_W    = 16,
  parameter int CAR_MAX  = 100,
  parameter int TICK_DIV = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [7:0]              modIdx,
  input  logic [1:0]              modeSel,
  output logic signed [4:0]       levelOut,
  output logic [11:0]             gateOut
);

  localparam int TRI_W = $clog2(CAR_MAX + 1);

  ctrlStrobe_t      strobe;
  logic [TRI_W-1:0] triVal;

  lvl_pwm_ctrl #(
    .CAR_MAX (CAR_MAX),
    .TICK_DIV(TICK_DIV),
    .TRI_W   (TRI_W)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .triVal(triVal)
  );

  lvl_pwm_datapath #(
    .REF_W  (REF_W),
    .CAR_MAX(CAR_MAX),
    .TRI_W  (TRI_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .triVal  (triVal),
    .refIn   (refIn),
    .modIdx  (modIdx),
    .modeSel (modeSel),
    .levelOut(levelOut),
    .gateOut (gateOut)
  );

endmodule

// File: rtl/lvl_pwm_checker.sv
module lvl_pwm_checker (
  input logic              clk,
  input logic              rst,
  input logic signed [4:0] levelOut,
  input logic [11:0]       gateOut
);

  logic [4:0] absLvl;
  int         legSum;
  assign absLvl = (levelOut < 0) ? 5'(-levelOut) : 5'(levelOut);
  assign legSum = int'(gateOut[0]) + 2 * int'(gateOut[2])
                + 3 * int'(gateOut[4]) + 4 * int'(gateOut[6]);

  a_r9_pairs_exclusive: assert property (@(posedge clk) disable iff (rst)
    ((gateOut[0] & gateOut[1]) | (gateOut[2] & gateOut[3]) |
     (gateOut[4] & gateOut[5]) | (gateOut[6] & gateOut[7])) == 1'b0);

  a_r10_bridge_exclusive: assert property (@(posedge clk) disable iff (rst)
    !((|gateOut[9:8]) && (|gateOut[11:10])));

  a_r10_bridge_sign: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (gateOut[11:8] == ((levelOut < 0) ? 4'b1100 : 4'b0011)));

  a_r7_level_range: assert property (@(posedge clk) disable iff (rst)
    (levelOut >= -5'sd10) && (levelOut <= 5'sd10));

  a_r8_weighted_sum: assert property (@(posedge clk) disable iff (rst)
    legSum == int'(absLvl));

  a_r11_gates_follow_level: assert property (@(posedge clk) disable iff (rst)
    !$stable(gateOut) |-> (!$stable(levelOut) || ($past(gateOut[11:8]) == 4'b0000)));

  a_r12_reset_state: assert property (@(posedge clk)
    rst |=> (levelOut == 5'sd0) && (gateOut == 12'h0AA));

endmodule

bind lvl_pwm_mod lvl_pwm_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .levelOut(levelOut),
  .gateOut (gateOut)
);

// File: tb/lvl_pwm_mod_test.sv
module lvl_pwm_mod_test;

  localparam int REF_W   = 12;
  localparam int CAR_MAX = 8;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic signed [REF_W-1:0] refIn = '0;
  logic [7:0]              modIdx = 8'd128;
  logic [1:0]              modeSel = 2'd0;
  logic signed [4:0]       levelOut;
  logic [11:0]             gateOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int heldRef, heldMi, heldMode;
  bit havePrev = 0;
  int prevLvl;
  logic [11:0] prevGate;

  lvl_pwm_mod #(.REF_W(REF_W), .CAR_MAX(CAR_MAX), .TICK_DIV(1)) uut (
    .clk(clk), .rst(rst), .refIn(refIn), .modIdx(modIdx),
    .modeSel(modeSel), .levelOut(levelOut), .gateOut(gateOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic int triAt(int n);
    int m = n % (2 * CAR_MAX);
    return (m <= CAR_MAX) ? m : 2 * CAR_MAX - m;
  endfunction

  function automatic int modelLevel(int r, int mi, int mode, int t);
    int s = (r * mi) >>> 7;
    int pos = 0, neg = 0, lv;
    for (int b = 0; b < 10; b++) begin
      bit pInv = (mode == 2) && (b % 2 == 1);
      bit nInv = (mode == 1) || ((mode == 2) && (b % 2 == 0));
      int pc = b * CAR_MAX + (pInv ? CAR_MAX - t : t);
      int nc = -(b + 1) * CAR_MAX + (nInv ? CAR_MAX - t : t);
      if (s > pc) pos++;
      if (nc > s) neg++;
    end
    lv = pos - neg;
    if (lv > 10) lv = 10;
    if (lv < -10) lv = -10;
    return lv;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkGates(int lv);
    int mag = (lv < 0) ? -lv : lv;
    int sum = int'(gateOut[0]) + 2 * int'(gateOut[2]) + 3 * int'(gateOut[4]) + 4 * int'(gateOut[6]);
    int legs = int'({gateOut[6], gateOut[4], gateOut[2], gateOut[0]});
    int pairs = int'((gateOut[0] & gateOut[1]) | (gateOut[2] & gateOut[3]) |
                     (gateOut[4] & gateOut[5]) | (gateOut[6] & gateOut[7]));
    int allLeg = int'(gateOut[0] | gateOut[1]) + int'(gateOut[2] | gateOut[3]) +
                 int'(gateOut[4] | gateOut[5]) + int'(gateOut[6] | gateOut[7]);
    int expBr = (lv < 0) ? 12 : 3;
    chk(sum == mag, "R8", "leg weight sum", sum, mag);
    if (mag == 5) chk(legs == 9, "R8", "legs for 5", legs, 9);
    if (mag == 6) chk(legs == 7, "R8", "legs for 6", legs, 7);
    if (mag == 9) chk(legs == 14, "R8", "legs for 9", legs, 14);
    chk(pairs == 0 && allLeg == 4, "R9", "leg pair exclusivity", pairs, 0);
    chk(int'(gateOut[11:8]) == expBr, "R10", "bridge", int'(gateOut[11:8]), expBr);
  endtask

  // checks the result of the previous inputs, then applies the next ones
  task automatic step(int r, int mi, int mode, string tag);
    int lv, act;
    @(negedge clk);
    lv  = modelLevel(heldRef, heldMi, heldMode, triAt(cyc - 1));
    act = int'(levelOut);
    chk(act == lv, tag, "level", act, lv);
    checkGates(act);
    if (havePrev && act == prevLvl)
      chk(gateOut == prevGate, "R11", "gates held with level", int'(gateOut), int'(prevGate));
    havePrev = 1;
    prevLvl  = act;
    prevGate = gateOut;
    refIn   = REF_W'(r);
    modIdx  = 8'(mi);
    modeSel = 2'(mode);
    heldRef = r; heldMi = mi; heldMode = mode;
  endtask

  task automatic sweep(int mi, int mode, string tag);
    for (int r = -90; r <= 90; r++) step(r, mi, mode, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(levelOut == 0, "R12", "reset level", int'(levelOut), 0);
    chk(gateOut == 12'h0AA, "R12", "reset gates", int'(gateOut), 'h0AA);
    heldRef = -90; heldMi = 128; heldMode = 0;
    refIn = REF_W'(-90); modIdx = 8'd128; modeSel = 2'd0;
    rst = 1'b0;
    // R1, R2 covered by every level check through the triangle model
    sweep(128, 0, "R3");
    sweep(128, 0, "R3");
    sweep(128, 3, "R3");
    sweep(128, 1, "R4");
    sweep(128, 1, "R4");
    sweep(128, 2, "R5");
    sweep(128, 2, "R5");
    sweep(64, 1, "R6");
    sweep(100, 2, "R6");
    sweep(160, 0, "R7");
    sweep(255, 2, "R7");
    step(0, 128, 0, "R7");
    // R12: reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(levelOut == 0, "R12", "re-reset level", int'(levelOut), 0);
    chk(gateOut == 12'h0AA, "R12", "re-reset gates", int'(gateOut), 'h0AA);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule